// File: doc/BRIEF.md
# Reset and boot vector sequencer

This block decides when a small 8-bit CPU core leaves reset and where it starts. It has four reset inputs: a power-on flag, an active-low external reset pin, a flag saying the clock was stopped when the pin was pulled, and a two-bit option that picks how long the oscillator needs to settle. After a power-on reset, or after a pin reset that arrives while the core was stopped, the block waits for a settling time. A free-running timebase divider measures that time. Other pin resets skip the wait. In every case the block holds the core until the pin is released.

Once reset ends, the block reads three bytes over a byte-wide port with a one-cycle read latency. The first byte is a mode byte. The other two are the high and low halves of the start address. The block then presents that address together with a run signal. It also latches the level of a mode strap while in reset and drives the latched value as the fetch-source select. A build option removes the settling wait completely, for parts that have no power-on detector. On such parts the length of the pin pulse alone sets the reset length.

Top module: `rst_boot_seq`

## Requirements
- R1: The first read goes to address 0xFFFD and returns the mode byte. Only 0x00 is legal. Any other value sets `mode_error_o`. The flag stays set through later pin resets and is cleared only by `por_i`.
- R2: The byte read from 0xFFFE becomes bits 15:8 of `start_addr_o`, and the byte read from 0xFFFF becomes bits 7:0.
- R3: A boot makes exactly three reads, one on each of three consecutive cycles, at 0xFFFD, 0xFFFE and 0xFFFF in that order. Each read's data is taken one cycle after its request. No read is made while `cpu_run_o` is high.
- R4: After `por_i` is released with the pin high, `cpu_run_o` stays low for at least 2^(STAB_EXP0+2·s) clocks, where s is `stab_sel_i` (0 to 3). It rises within 14 clocks after that time.
- R5: A pin reset taken while `stop_mode_i` is 1 restarts the settling wait on the running timebase. `cpu_run_o` rises no sooner than 2^(STAB_EXP0+2·s−1) clocks after the pin falls.
- R6: A pin reset taken while `stop_mode_i` is 0 has no settling wait. `cpu_run_o` rises within 10 clocks of the pin's release.
- R7: If the settling time has elapsed but the pin is still low, the core stays held with no reads. It starts within 10 clocks of the pin's release.
- R8: `fetch_src_o` follows `mode_pin_i` only while the block is waiting in reset. A change of `mode_pin_i` after the fetch has begun does not change it.
- R9: While `ext_rst_n` is low, `cpu_run_o` and `rd_en_o` are low, and both drop without waiting for a clock. After reset `cpu_run_o` rises once and stays high, with a stable `start_addr_o`.
- R10: With HAS_POR=0 there is no settling wait after `por_i` either. `cpu_run_o` rises within 10 clocks after both resets are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| stop_mode_i | input | 1 | Core was in stop mode when the pin reset arrived |
| stab_sel_i | input | 2 | Settling time option s, delay 2^(STAB_EXP0+2·s) clocks |
| mode_pin_i | input | 1 | Mode strap, sampled during reset |
| rd_en_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | DATA_W | Read data, valid one cycle after the request |
| start_addr_o | output | ADDR_W | Start address for the core |
| fetch_src_o | output | 1 | Latched mode strap, the fetch-source select |
| cpu_run_o | output | 1 | Core may execute |
| mode_error_o | output | 1 | Sticky flag: illegal mode byte seen |

## Verification
The boot path is tried from several starting points:
- a cold start at two different settling options, which shows that the chosen timebase tap sets the wait;
- a plain pin pulse, which must skip the wait;
- a pin pulse taken from stop mode, which must wait on the timebase's current phase;
- a power-on reset while the pin stays low past the settling time, which shows that the pin, not the timer, ends the reset.

Each run uses different vector bytes, so a swap of the high and low halves shows up as a wrong address. A nonzero mode byte followed by a clean pin reset separates a sticky error flag from one that a pin reset clears. A second instance built without power-on support, sharing the same stimulus, confirms that its settling wait is gone.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

   typedef enum logic [1:0] {
      PH_WAIT,
      PH_FETCH,
      PH_RUN
   } phase_e;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_MODE,
      FS_HI,
      FS_LO,
      FS_LAST
   } fstep_e;

   localparam int TAP_COUNT = 4;

   // timebase bit whose second toggle marks 2^(exp0 + 2*sel) clocks
   function automatic int tap_index(input int exp0, input int sel);
      return exp0 - 1 + 2 * sel;
   endfunction

endpackage

// File: rtl/rbs_sync.sv
module rbs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic pin_ok
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign pin_ok = chain_q[STAGES-1];

endmodule

// File: rtl/rbs_stab.sv
module rbs_stab #(
   parameter int HAS_POR   = 1,
   parameter int STAB_EXP0 = 12
) (
   input  logic       clk,
   input  logic       por_i,
   input  logic       restart,
   input  logic [1:0] sel,
   output logic       done
);
   import rbs_pkg::*;

   localparam int TB_W = tap_index(STAB_EXP0, TAP_COUNT - 1) + 1;

   generate
      if (HAS_POR != 0) begin : g_tb
         logic [TB_W-1:0]      tb_q;
         logic [TAP_COUNT-1:0] cand;
         logic                 tap;
         logic                 prev_q;
         logic [1:0]           tog_q;

         // free-running divider, only power-on clears it
         always_ff @(posedge clk or posedge por_i) begin
            if (por_i) tb_q <= '0;
            else       tb_q <= tb_q + TB_W'(1);
         end

         for (genvar i = 0; i < TAP_COUNT; i++) begin : g_tap
            assign cand[i] = tb_q[tap_index(STAB_EXP0, i)];
         end

         assign tap = cand[sel];

         always_ff @(posedge clk or posedge por_i) begin
            if (por_i) begin
               prev_q <= 1'b0;
               tog_q  <= 2'd0;
            end else if (restart) begin
               prev_q <= tap;
               tog_q  <= 2'd0;
            end else begin
               prev_q <= tap;
               if ((tap != prev_q) && (tog_q != 2'd2)) tog_q <= tog_q + 2'd1;
            end
         end

         assign done = (tog_q == 2'd2);
      end else begin : g_none
         assign done = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/rbs_fetch.sv
module rbs_fetch #(
   parameter int               DATA_W     = 8,
   parameter int               ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFFFD,
   parameter logic [DATA_W-1:0] LEGAL_MODE = '0
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              go,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic [ADDR_W-1:0] start_addr_o,
   output logic              mode_bad,
   output logic              last
);
   import rbs_pkg::*;

   fstep_e            step_q;
   logic [DATA_W-1:0] hi_q;
   logic [1:0]        ofs;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) step_q <= FS_IDLE;
      else begin
         unique case (step_q)
            FS_IDLE: if (go) step_q <= FS_MODE;
            FS_MODE: step_q <= FS_HI;
            FS_HI:   step_q <= FS_LO;
            FS_LO:   step_q <= FS_LAST;
            default: step_q <= FS_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (step_q)
         FS_HI:   ofs = 2'd1;
         FS_LO:   ofs = 2'd2;
         default: ofs = 2'd0;
      endcase
   end

   assign rd_en_o   = (step_q == FS_MODE) || (step_q == FS_HI) || (step_q == FS_LO);
   assign rd_addr_o = MODE_ADDR + ADDR_W'(ofs);

   // data lags its request by one cycle
   assign mode_bad = (step_q == FS_HI) && (rd_data_i != LEGAL_MODE);
   assign last     = (step_q == FS_LAST);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hi_q         <= '0;
         start_addr_o <= '0;
      end else begin
         if (step_q == FS_LO)   hi_q         <= rd_data_i;
         if (step_q == FS_LAST) start_addr_o <= {hi_q, rd_data_i};
      end
   end

endmodule

// File: rtl/rst_boot_seq.sv
module rst_boot_seq #(
   parameter int                DATA_W      = 8,
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] MODE_ADDR   = 16'hFFFD,
   parameter logic [DATA_W-1:0] LEGAL_MODE  = '0,
   parameter int                HAS_POR     = 1,
   parameter int                STAB_EXP0   = 12,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_i,
   input  logic              ext_rst_n,
   input  logic              stop_mode_i,
   input  logic [1:0]        stab_sel_i,
   input  logic              mode_pin_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [ADDR_W-1:0] start_addr_o,
   output logic              fetch_src_o,
   output logic              cpu_run_o,
   output logic              mode_error_o
);
   import rbs_pkg::*;

   localparam logic POR_STAB = (HAS_POR != 0);

   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("ADDR_W must be twice DATA_W");
   end
   if (STAB_EXP0 < 1) begin : g_bad_exp
      $error("STAB_EXP0 must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ({1'b0, MODE_ADDR} + (ADDR_W + 1)'(2) > {1'b0, {ADDR_W{1'b1}}}) begin : g_bad_addr
      $error("MODE_ADDR leaves no room for the two vector bytes");
   end

   logic   arst_n;
   logic   pin_ok;
   logic   ext_hold;
   logic   ext_hold_q;
   logic   stop_entry;
   logic   stab_done;
   logic   need_stab_q;
   logic   go;
   logic   mode_bad;
   logic   last;
   phase_e phase_q;

   // either source pulls reset at once; release goes through the synchronizer
   assign arst_n = ext_rst_n & ~por_i;

   rbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .pin_ok (pin_ok)
   );

   assign ext_hold = ~pin_ok;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) ext_hold_q <= 1'b1;
      else       ext_hold_q <= ext_hold;
   end

   assign stop_entry = POR_STAB & ext_hold & ~ext_hold_q & stop_mode_i;

   rbs_stab #(.HAS_POR(HAS_POR), .STAB_EXP0(STAB_EXP0)) u_stab (
      .clk     (clk),
      .por_i   (por_i),
      .restart (stop_entry),
      .sel     (stab_sel_i),
      .done    (stab_done)
   );

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i)           need_stab_q <= POR_STAB;
      else if (stop_entry) need_stab_q <= 1'b1;
      else if (go)         need_stab_q <= 1'b0;
   end

   assign go = (phase_q == PH_WAIT) && !ext_hold && (!need_stab_q || stab_done);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) phase_q <= PH_WAIT;
      else begin
         unique case (phase_q)
            PH_WAIT:  if (go)   phase_q <= PH_FETCH;
            PH_FETCH: if (last) phase_q <= PH_RUN;
            default:            phase_q <= PH_RUN;
         endcase
      end
   end

   rbs_fetch #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .MODE_ADDR  (MODE_ADDR),
      .LEGAL_MODE (LEGAL_MODE)
   ) u_fetch (
      .clk          (clk),
      .arst_n       (arst_n),
      .go           (go),
      .rd_data_i    (rd_data_i),
      .rd_en_o      (rd_en_o),
      .rd_addr_o    (rd_addr_o),
      .start_addr_o (start_addr_o),
      .mode_bad     (mode_bad),
      .last         (last)
   );

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i)         mode_error_o <= 1'b0;
      else if (mode_bad) mode_error_o <= 1'b1;
   end

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i)                   fetch_src_o <= 1'b0;
      else if (phase_q == PH_WAIT) fetch_src_o <= mode_pin_i;
   end

   assign cpu_run_o = (phase_q == PH_RUN);

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 16'hFFFD
) (
   input logic              clk,
   input logic              por_i,
   input logic              ext_rst_n,
   input logic              rd_en_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic [ADDR_W-1:0] start_addr_o,
   input logic              fetch_src_o,
   input logic              cpu_run_o,
   input logic              mode_error_o
);

   a_r3_mode_then_hi: assert property (@(posedge clk) disable iff (por_i || !ext_rst_n)
      (rd_en_o && rd_addr_o == MODE_ADDR) |=> (rd_en_o && rd_addr_o == MODE_ADDR + ADDR_W'(1)));

   a_r3_hi_then_lo: assert property (@(posedge clk) disable iff (por_i || !ext_rst_n)
      (rd_en_o && rd_addr_o == MODE_ADDR + ADDR_W'(1)) |=> (rd_en_o && rd_addr_o == MODE_ADDR + ADDR_W'(2)));

   a_r3_no_read_running: assert property (@(posedge clk) disable iff (por_i)
      cpu_run_o |-> !rd_en_o);

   a_r9_pin_blocks: assert property (@(posedge clk) disable iff (por_i)
      !ext_rst_n |-> (!cpu_run_o && !rd_en_o));

   a_r9_run_holds: assert property (@(posedge clk) disable iff (por_i || !ext_rst_n)
      cpu_run_o |=> cpu_run_o);

   a_r2_addr_stable: assert property (@(posedge clk) disable iff (por_i || !ext_rst_n)
      (cpu_run_o && $past(cpu_run_o)) |-> $stable(start_addr_o));

   a_r8_src_frozen: assert property (@(posedge clk) disable iff (por_i || !ext_rst_n)
      (cpu_run_o && $past(cpu_run_o)) |-> $stable(fetch_src_o));

   a_r1_err_sticky: assert property (@(posedge clk) disable iff (por_i)
      mode_error_o |=> mode_error_o);

endmodule

bind rst_boot_seq rbs_checker #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_chk (
   .clk          (clk),
   .por_i        (por_i),
   .ext_rst_n    (ext_rst_n),
   .rd_en_o      (rd_en_o),
   .rd_addr_o    (rd_addr_o),
   .start_addr_o (start_addr_o),
   .fetch_src_o  (fetch_src_o),
   .cpu_run_o    (cpu_run_o),
   .mode_error_o (mode_error_o)
);

// File: tb/sim_rst_boot_seq.sv
`timescale 1ns/1ps
module sim_rst_boot_seq;

   localparam int E = 4;

   logic        clk = 1'b0;
   always #2 clk = ~clk;

   logic        por = 1'b1;
   logic        ext_n = 1'b1;
   logic        stop = 1'b0;
   logic [1:0]  sel = 2'd0;
   logic        mpin = 1'b0;

   logic        rd_en0, rd_en1;
   logic [15:0] rd_addr0, rd_addr1;
   logic [7:0]  rd_data0, rd_data1;
   logic [15:0] start0, start1;
   logic        src0, src1, run0, run1, err0, err1;

   logic [7:0]  rom_mode = 8'h00, rom_hi = 8'h12, rom_lo = 8'h34;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int t_ref  = 0;

   typedef struct {
      logic [15:0] addr;
      bit          err;
      bit          src;
      int          lo;
      int          hi;
      string       req;
   } exp_t;
   exp_t q[$];

   rst_boot_seq #(.STAB_EXP0(E)) u0 (
      .clk(clk), .por_i(por), .ext_rst_n(ext_n), .stop_mode_i(stop), .stab_sel_i(sel),
      .mode_pin_i(mpin), .rd_en_o(rd_en0), .rd_addr_o(rd_addr0), .rd_data_i(rd_data0),
      .start_addr_o(start0), .fetch_src_o(src0), .cpu_run_o(run0), .mode_error_o(err0));

   rst_boot_seq #(.STAB_EXP0(E), .HAS_POR(0)) u1 (
      .clk(clk), .por_i(por), .ext_rst_n(ext_n), .stop_mode_i(stop), .stab_sel_i(sel),
      .mode_pin_i(mpin), .rd_en_o(rd_en1), .rd_addr_o(rd_addr1), .rd_data_i(rd_data1),
      .start_addr_o(start1), .fetch_src_o(src1), .cpu_run_o(run1), .mode_error_o(err1));

   function automatic logic [7:0] byte_at(input logic [15:0] a);
      case (a)
         16'hFFFD: return rom_mode;
         16'hFFFE: return rom_hi;
         16'hFFFF: return rom_lo;
         default:  return 8'hEE;
      endcase
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rd_en0) rd_data0 <= byte_at(rd_addr0);
      if (rd_en1) rd_data1 <= byte_at(rd_addr1);
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [15:0] a, input bit e, input bit s,
                       input int lo, input int hi, input string req);
      exp_t x;
      x.addr = a; x.err = e; x.src = s; x.lo = lo; x.hi = hi; x.req = req;
      q.push_back(x);
   endtask

   // monitor: read log and scoreboard compare on each run rise
   logic        run_q = 1'b0;
   logic [15:0] log_a [4];
   int          log_c [4];
   int          nrd = 0;

   always @(negedge clk) begin
      if (rd_en0) begin
         if (nrd < 4) begin
            log_a[nrd] = rd_addr0;
            log_c[nrd] = cyc;
         end
         nrd++;
      end
      if (run0 && !run_q) begin
         if (q.size() == 0) begin
            chk(1'b0, "R9", "unexpected run", 32'(run0), 32'd0);
         end else begin
            exp_t e;
            int   lat;
            e   = q.pop_front();
            lat = cyc - t_ref;
            chk(start0 == e.addr, "R2", {e.req, " start address"}, 32'(start0), 32'(e.addr));
            chk(err0 == e.err, "R1", {e.req, " mode error"}, 32'(err0), 32'(e.err));
            chk(src0 == e.src, "R8", {e.req, " fetch source"}, 32'(src0), 32'(e.src));
            chk(lat >= e.lo && lat <= e.hi, e.req, "run latency", 32'(lat), 32'(e.lo));
            chk(nrd == 3, "R3", "read count", 32'(nrd), 32'd3);
            if (nrd == 3) begin
               chk(log_a[0] == 16'hFFFD && log_a[1] == 16'hFFFE && log_a[2] == 16'hFFFF,
                   "R3", "read order", {log_a[0], log_a[2]}, 32'hFFFDFFFF);
               chk(log_c[1] == log_c[0] + 1 && log_c[2] == log_c[1] + 1,
                   "R3", "reads back to back", 32'(log_c[2] - log_c[0]), 32'd2);
            end
         end
         nrd = 0;
      end
      run_q = run0;
   end

   task automatic wait_run(input int limit);
      int n = 0;
      while (!run0 && n < limit) begin
         @(negedge clk);
         n++;
      end
      if (n >= limit) chk(1'b0, "R9", "run never rose", 32'(run0), 32'd1);
      repeat (2) @(negedge clk);
   endtask

   task automatic pin_pulse(input int len);
      ext_n = 1'b0;
      repeat (len) @(negedge clk);
      ext_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(run0 == 1'b0, "R9", "run in reset", 32'(run0), 32'd0);
      chk(rd_en0 == 1'b0, "R9", "read in reset", 32'(rd_en0), 32'd0);
      chk(err0 == 1'b0, "R1", "error in reset", 32'(err0), 32'd0);
      chk(run1 == 1'b0, "R10", "no-por run in reset", 32'(run1), 32'd0);

      // cold start, option 0
      push(16'h1234, 1'b0, 1'b0, 16, 30, "R4");
      por = 1'b0;
      t_ref = cyc;
      repeat (10) @(negedge clk);
      chk(run1 == 1'b1, "R10", "no-por instance running", 32'(run1), 32'd1);
      chk(start1 == 16'h1234, "R10", "no-por start address", 32'(start1), 32'h1234);
      chk(run0 == 1'b0, "R4", "still settling", 32'(run0), 32'd0);
      wait_run(2000);

      // strap change while running
      mpin = 1'b1;
      repeat (4) @(negedge clk);
      chk(src0 == 1'b0, "R8", "source after strap change", 32'(src0), 32'd0);

      // plain pin reset, strap high during reset
      rom_hi = 8'hAB; rom_lo = 8'hCD;
      ext_n = 1'b0;
      #1;
      chk(run0 == 1'b0, "R9", "run drops at once", 32'(run0), 32'd0);
      repeat (3) @(negedge clk);
      chk(rd_en0 == 1'b0, "R9", "no read while pin low", 32'(rd_en0), 32'd0);
      push(16'hABCD, 1'b0, 1'b1, 0, 10, "R6");
      ext_n = 1'b1;
      t_ref = cyc;
      wait_run(2000);
      mpin = 1'b0;
      repeat (4) @(negedge clk);
      chk(src0 == 1'b1, "R8", "source held after strap drop", 32'(src0), 32'd1);

      // pin reset from stop mode, option 1
      sel = 2'd1; stop = 1'b1;
      rom_hi = 8'h5A; rom_lo = 8'hA5;
      push(16'h5AA5, 1'b0, 1'b0, 32, 80, "R5");
      t_ref = cyc;
      pin_pulse(3);
      repeat (2) @(negedge clk);
      stop = 1'b0;
      wait_run(2000);

      // power-on while pin held past the settling time
      sel = 2'd0;
      ext_n = 1'b0;
      por = 1'b1;
      repeat (2) @(negedge clk);
      por = 1'b0;
      repeat (60) @(negedge clk);
      chk(run0 == 1'b0, "R7", "held by pin after settling", 32'(run0), 32'd0);
      chk(rd_en0 == 1'b0, "R7", "no read while held", 32'(rd_en0), 32'd0);
      rom_hi = 8'h0F; rom_lo = 8'hF0;
      push(16'h0FF0, 1'b0, 1'b0, 0, 10, "R7");
      ext_n = 1'b1;
      t_ref = cyc;
      wait_run(2000);

      // illegal mode byte
      rom_mode = 8'h05; rom_hi = 8'h11; rom_lo = 8'h22;
      push(16'h1122, 1'b1, 1'b0, 0, 10, "R1");
      pin_pulse(3);
      t_ref = cyc;
      wait_run(2000);

      // legal byte again, flag must stay
      rom_mode = 8'h00; rom_hi = 8'h33;
      push(16'h3322, 1'b1, 1'b0, 0, 10, "R1");
      pin_pulse(3);
      t_ref = cyc;
      wait_run(2000);

      // power-on clears flag, option 2
      sel = 2'd2;
      rom_hi = 8'h77; rom_lo = 8'h88;
      por = 1'b1;
      repeat (2) @(negedge clk);
      chk(err0 == 1'b0, "R1", "power-on clears error", 32'(err0), 32'd0);
      push(16'h7788, 1'b0, 1'b0, 256, 270, "R4");
      por = 1'b0;
      t_ref = cyc;
      wait_run(3000);

      chk(q.size() == 0, "R9", "pending boots", 32'(q.size()), 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule